// File: doc/BRIEF.md
# SHA-256 Message Padding Unit

This unit sits in front of a SHA-256 compression core. It takes a message one byte at a time over a valid/ready handshake and hands out complete 64-byte blocks. A message may span any number of transfers. Bytes that do not yet fill a block stay in an internal buffer until more input arrives. A last-byte marker ends the message. The unit then appends the mandatory 0x80 marker, the zero fill and the message length in bits. If the tail of the message leaves too little room for the length, the unit emits a second block.

Each block leaves on a 512-bit bus as sixteen big-endian 32-bit words. Byte 0 of the block is in the top eight bits. A final-block flag marks the one block after which the downstream core should write back its digest. The unit keeps a 32-bit bit count. The length is therefore the bit count modulo 2^32, and the upper four bytes of the 8-byte length field are always zero. An empty message is ended by a transfer that carries the last marker and has its no-data qualifier set. A synchronous clear drops a message that is in progress.

Top module: `sha256_pad`

## Requirements
- R1: A block leaves only when all 64 bytes are known. Block byte i appears on `out_block[511-8*i -: 8]`, so word 0 is in bits 511:480 with its first byte most significant. Blocks made only of message data have `out_final` low.
- R2: Message bytes are packed back to back across blocks. A byte's block position is its message index modulo 64, and leftover bytes carry over into the next block.
- R3: At end of message, byte 0x80 follows the last data byte directly. Every byte after it is zero, except the length field.
- R4: If the 0x80 byte lands at position 56 or later, that block is emitted with no length and with `out_final` low. An extra block follows that is zero except for the length, with `out_final` high.
- R5: Bytes 60 to 63 of the final block hold (message bytes × 8) mod 2^32, most significant byte first.
- R6: Bytes 56 to 59 of the final block are always zero.
- R7: A transfer with `in_last`=1 and `in_nodata`=1 ends the message without adding a byte. For an empty message this gives one final block with 0x80 at byte 0 and zeros everywhere else.
- R8: `in_ready` is high and `out_valid` is low when the unit is idle. `in_ready` is low for as long as a block is waiting on the output.
- R9: `out_final` is high only on the last block of a message.
- R10: While `out_valid` is high and `out_ready` is low, `out_block` and `out_final` hold their values.
- R11: After the final block is accepted, the unit is idle again on the next cycle, and the next message starts from a byte count of zero.
- R12: A cycle with `clr` high drops any pending block, the buffered bytes and the byte count. On the next cycle the unit is idle.
- R13: A transfer with `in_nodata`=1 and `in_last`=0 is accepted and has no effect on the message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of the current message |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Unit can take an input transfer |
| in_data | input | 8 | Message byte |
| in_last | input | 1 | This transfer ends the message |
| in_nodata | input | 1 | Transfer carries no byte (in_data ignored) |
| out_valid | output | 1 | A block is presented |
| out_ready | input | 1 | Downstream takes the block |
| out_block | output | 512 | Block as 16 big-endian words, byte 0 in the top bits |
| out_final | output | 1 | Presented block is the last of the message |

## Verification
The hold and no-accept properties rely on the environment never asserting `clr` in the same cycle as a transfer it expects to count. The bench keeps `clr` apart from every handshake, and it pulses `clr` only while `in_valid` and `out_ready` are both low. The properties also rely on `in_data` being ignored when `in_nodata` is set. The bench drives a marker value there to make any leak into a block show up. The output side is stalled for one cycle on every block, so the hold property and the input stall are exercised on each block, including padding-only and length-only blocks.

// File: rtl/sha_pad_pkg.sv
// Shared constants and types for the SHA-256 padding unit.
package sha_pad_pkg;
    localparam int BLK_BYTES = 64;
    localparam int IDX_W     = $clog2(BLK_BYTES);
    localparam int BLK_W     = BLK_BYTES * 8;
    localparam int LEN_BYTES = 8;
    localparam int LEN_START = BLK_BYTES - LEN_BYTES;
    localparam logic [7:0] PAD_MARK = 8'h80;

    typedef enum logic [1:0] {
        ST_FILL = 2'd0,
        ST_DATA = 2'd1,
        ST_PAD  = 2'd2,
        ST_LEN  = 2'd3
    } pad_state_e;

    typedef enum logic [1:0] {
        FMT_RAW = 2'd0,
        FMT_PAD = 2'd1,
        FMT_LEN = 2'd2
    } fmt_mode_e;
endpackage

// File: rtl/sha_pad_count.sv
// Message byte counter.
// Counts accepted data bytes. The width is the bit-count width minus three,
// so (count << 3) wraps exactly like the length field.
// Assumes clr and rst_n are synchronous.
module sha_pad_count #(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    // Count data bytes; clear or reset returns to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/sha_pad_buf.sv
// Block byte store.
// Holds one block of bytes. Each byte has a register written when the write
// index matches. Stale bytes past the fill point are not cleared; the
// formatter masks them.
module sha_pad_buf
    import sha_pad_pkg::*;
#(
    parameter int NBYTES = BLK_BYTES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [IDX_W-1:0]      widx,
    input  logic [7:0]            wdata,
    output logic [NBYTES*8-1:0]   raw
);
    for (genvar i = 0; i < NBYTES; i++) begin : g_slot
        localparam logic [IDX_W-1:0] SLOT = IDX_W'(i);
        // Capture the incoming byte when it targets this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                raw[8*i +: 8] <= 8'h00;
            end else if (we && (widx == SLOT)) begin
                raw[8*i +: 8] <= wdata;
            end
        end
    end
endmodule

// File: rtl/sha_pad_fmt.sv
// Output block formatter (combinational).
// Builds the outgoing block from the stored bytes:
//   RAW - stored bytes as they are;
//   PAD - stored bytes below fill_idx, 0x80 at fill_idx, zeros above,
//         plus the length field when with_len is set;
//   LEN - zeros with the length field.
// The length field sits in the last LEN_BYTES bytes, most significant byte
// first. The bit count is zero-extended into it.
// Byte 0 is driven onto the top eight bits of blk.
module sha_pad_fmt
    import sha_pad_pkg::*;
#(
    parameter int NBYTES     = BLK_BYTES,
    parameter int LEN_BITS_W = 32
) (
    input  logic [NBYTES*8-1:0]    raw,
    input  fmt_mode_e              mode,
    input  logic [IDX_W-1:0]       fill_idx,
    input  logic                   with_len,
    input  logic [LEN_BITS_W-4:0]  byte_cnt,
    output logic [NBYTES*8-1:0]    blk
);
    localparam int FIELD_W = 8 * LEN_BYTES;

    logic [LEN_BITS_W-1:0] bit_cnt;
    logic [FIELD_W-1:0]    len_field;

    // Bit count with its wrap, zero-extended to the field width.
    always_comb begin
        bit_cnt   = {byte_cnt, 3'b000};
        len_field = FIELD_W'(bit_cnt);
    end

    for (genvar i = 0; i < NBYTES; i++) begin : g_out
        localparam logic [IDX_W-1:0] POS = IDX_W'(i);
        logic [7:0] len_b;
        logic [7:0] out_b;

        if (i >= LEN_START) begin : g_field
            assign len_b = len_field[8*(NBYTES-1-i) +: 8];
        end else begin : g_nofield
            assign len_b = 8'h00;
        end

        // Select the value of this byte for the current block kind.
        always_comb begin
            out_b = 8'h00;
            unique case (mode)
                FMT_RAW: out_b = raw[8*i +: 8];
                FMT_PAD: begin
                    if (POS < fill_idx) begin
                        out_b = raw[8*i +: 8];
                    end else if (POS == fill_idx) begin
                        out_b = PAD_MARK;
                    end else if (with_len) begin
                        out_b = len_b;
                    end
                end
                FMT_LEN: out_b = len_b;
                default: out_b = 8'h00;
            endcase
        end

        assign blk[NBYTES*8-1-8*i -: 8] = out_b;
    end
endmodule

// File: rtl/sha256_pad.sv
// SHA-256 message padding unit (top).
// Takes message bytes over valid/ready and emits 64-byte blocks with the
// end-of-message padding and a 32-bit bit-length field. Input is stalled
// while any block waits on the output. One block is presented at a time.
// Assumes a single clock, synchronous active-low reset, and clr held apart
// from handshakes the caller wants counted.
module sha256_pad
    import sha_pad_pkg::*;
#(
    parameter int LEN_BITS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic             in_nodata,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [BLK_W-1:0] out_block,
    output logic             out_final
);
    localparam int CNT_W = LEN_BITS_W - 3;
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(BLK_BYTES - 1);
    localparam logic [IDX_W-1:0] LEN_SLOT  = IDX_W'(LEN_START);

    pad_state_e         state;
    logic               ending;
    logic [CNT_W-1:0]   byte_cnt;
    logic [IDX_W-1:0]   fill_idx;
    logic [BLK_W-1:0]   raw;
    fmt_mode_e          mode;
    logic               in_acc;
    logic               byte_we;
    logic               out_acc;
    logic               len_fits;
    logic               cnt_clr;

    // Handshake decode and derived controls.
    always_comb begin
        in_ready  = (state == ST_FILL);
        out_valid = (state != ST_FILL);
        fill_idx  = byte_cnt[IDX_W-1:0];
        len_fits  = (fill_idx < LEN_SLOT);
        in_acc    = in_valid && in_ready;
        byte_we   = in_acc && !in_nodata;
        out_acc   = out_valid && out_ready;
        out_final = ((state == ST_PAD) && len_fits) || (state == ST_LEN);
        cnt_clr   = clr || (out_acc && out_final);
    end

    // Map the control state to a formatter mode.
    always_comb begin
        unique case (state)
            ST_PAD:  mode = FMT_PAD;
            ST_LEN:  mode = FMT_LEN;
            default: mode = FMT_RAW;
        endcase
    end

    // Control sequence: fill, present data block, padding, length block.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state  <= ST_FILL;
            ending <= 1'b0;
        end else begin
            unique case (state)
                ST_FILL: begin
                    if (byte_we && (fill_idx == LAST_SLOT)) begin
                        state  <= ST_DATA;
                        ending <= in_last;
                    end else if (in_acc && in_last) begin
                        state <= ST_PAD;
                    end
                end
                ST_DATA: begin
                    if (out_acc) begin
                        state <= ending ? ST_PAD : ST_FILL;
                    end
                end
                ST_PAD: begin
                    if (out_acc) begin
                        state <= len_fits ? ST_FILL : ST_LEN;
                    end
                end
                ST_LEN: begin
                    if (out_acc) begin
                        state <= ST_FILL;
                    end
                end
                default: state <= ST_FILL;
            endcase
        end
    end

    sha_pad_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (byte_we),
        .count (byte_cnt)
    );

    sha_pad_buf #(
        .NBYTES (BLK_BYTES)
    ) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (byte_we),
        .widx  (fill_idx),
        .wdata (in_data),
        .raw   (raw)
    );

    sha_pad_fmt #(
        .NBYTES     (BLK_BYTES),
        .LEN_BITS_W (LEN_BITS_W)
    ) u_fmt (
        .raw      (raw),
        .mode     (mode),
        .fill_idx (fill_idx),
        .with_len (len_fits),
        .byte_cnt (byte_cnt),
        .blk      (out_block)
    );
endmodule

// File: rtl/sha256_pad_chk.sv
// Property checker for sha256_pad, attached by bind.
// Watches only the ports.
module sha256_pad_chk
    import sha_pad_pkg::*;
#(
    parameter int LEN_BITS_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_last,
    input logic             out_valid,
    input logic             out_ready,
    input logic [BLK_W-1:0] out_block,
    input logic             out_final
);
    localparam int HI_TOP = BLK_W - 1 - 8 * LEN_START;
    localparam int ZW     = 8 * LEN_BYTES - LEN_BITS_W;

    // R8
    busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R10
    hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !clr) |=>
            (out_valid && $stable(out_block) && $stable(out_final)));

    // R9
    final_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_final |-> out_valid);

    // R6
    len_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_final) |-> (out_block[HI_TOP -: ZW] == '0));

    // R11
    idle_after_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_final && !clr) |=> (in_ready && !out_valid));

    // R12
    clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (in_ready && !out_valid));

    // R3
    end_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last && !clr) |=> out_valid);
endmodule

bind sha256_pad sha256_pad_chk #(
    .LEN_BITS_W (LEN_BITS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_block (out_block),
    .out_final (out_final)
);

// File: tb/sha256_pad_bench.sv
// Self-checking bench for sha256_pad: table of messages, then directed cases.
module sha256_pad_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam int NVEC       = 12;
    // Message length, data seed, expected block count.
    // len 0 -> R7; len 56, 63, 120 -> R4 (extra length block); 64, 128, 200 -> R2
    localparam int V_LEN  [NVEC] = '{0, 1, 3, 55, 56, 63, 64, 65, 119, 120, 128, 200};
    localparam int V_SEED [NVEC] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12};
    localparam int V_NBLK [NVEC] = '{1, 1, 1, 1, 2, 2, 2, 2, 2, 3, 3, 4};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [7:0]   in_data = 8'h00;
    logic         in_last = 1'b0;
    logic         in_nodata = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [511:0] out_block;
    logic         out_final;

    int n_chk = 0;
    int n_fail = 0;

    sha256_pad u_sha256_pad (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_nodata (in_nodata),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_block (out_block),
        .out_final (out_final)
    );

    initial forever #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dbyte(input int k, input int seed);
        return 8'(k * 37 + seed * 11 + 5);
    endfunction

    // Expected byte at padded-message position p.
    function automatic logic [7:0] ebyte(input int len, input int seed, input int nb, input int p);
        int tot;
        logic [31:0] bits;
        tot  = nb * 64;
        bits = 32'(len * 8);
        if (p < len) return dbyte(p, seed);
        if (p == len) return 8'h80;
        if (p >= tot - 4) return bits[8*(tot-1-p) +: 8];
        return 8'h00;
    endfunction

    task automatic send_b(input logic [7:0] d, input bit last, input bit nod);
        @(negedge clk);
        in_valid  = 1'b1;
        in_data   = d;
        in_last   = last;
        in_nodata = nod;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic send_end();
        @(negedge clk);
        in_valid  = 1'b0;
        in_last   = 1'b0;
        in_nodata = 1'b0;
    endtask

    // Send a message; a no-data, non-last transfer is placed before byte gap.
    task automatic send_msg(input int len, input int seed, input int gap);
        for (int k = 0; k < len; k++) begin
            if (k == gap) send_b(8'hEE, 1'b0, 1'b1);
            send_b(dbyte(k, seed), (k == len - 1), 1'b0);
        end
        if (len == 0) send_b(8'hEE, 1'b1, 1'b1);
        send_end();
    endtask

    task automatic recv_msg(input int len, input int seed, input int nb);
        for (int b = 0; b < nb; b++) begin
            int bad;
            logic [7:0] av;
            logic [7:0] ev;
            logic [511:0] held;
            string tag;
            @(negedge clk);
            while (!out_valid) @(negedge clk);
            bad = -1;
            av = 8'h00;
            ev = 8'h00;
            for (int i = 0; i < 64; i++) begin
                if (bad < 0 && out_block[511-8*i -: 8] !== ebyte(len, seed, nb, b*64 + i)) begin
                    bad = i;
                    av  = out_block[511-8*i -: 8];
                    ev  = ebyte(len, seed, nb, b*64 + i);
                end
            end
            if (len == 0) tag = "R7 empty message block";
            else if ((len % 64) > 55 && b >= nb - 2) tag = "R4 R3 R5 split padding block";
            else tag = "R1 R2 R3 R5 R6 block content";
            chk(bad < 0, $sformatf("%s len=%0d blk=%0d byte=%0d", tag, len, b, bad), 64'(av), 64'(ev));
            chk(out_final == (b == nb - 1), $sformatf("R9 final flag len=%0d blk=%0d", len, b),
                64'(out_final), 64'(b == nb - 1));
            chk(!in_ready, "R8 input stalled while block pending", 64'(in_ready), 64'd0);
            held = out_block;
            @(negedge clk);
            chk(out_valid && (out_block == held), "R10 block held under stall",
                64'(out_valid), 64'd1);
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
        end
    endtask

    task automatic idle_chk(input string tag);
        chk(in_ready && !out_valid, tag, {62'd0, in_ready, out_valid}, 64'd2);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        idle_chk("R8 reset state idle");

        // Table of messages, back to back (R11: count restarts each message).
        for (int v = 0; v < NVEC; v++) begin
            fork
                send_msg(V_LEN[v], V_SEED[v], -1);
                recv_msg(V_LEN[v], V_SEED[v], V_NBLK[v]);
            join
            @(negedge clk);
            idle_chk($sformatf("R11 idle after message len=%0d", V_LEN[v]));
        end

        // R12: clear with a partial block buffered.
        for (int k = 0; k < 10; k++) send_b(8'h55, 1'b0, 1'b0);
        send_end();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        idle_chk("R12 idle after clear");
        fork
            send_msg(3, 9, -1);
            recv_msg(3, 9, 1);
        join

        // R12: clear with a full data block pending on the output.
        for (int k = 0; k < 64; k++) send_b(8'h33, 1'b0, 1'b0);
        send_end();
        chk(out_valid, "R12 data block pending before clear", 64'(out_valid), 64'd1);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        idle_chk("R12 pending block dropped by clear");
        fork
            send_msg(5, 13, -1);
            recv_msg(5, 13, 1);
        join

        // R13: a no-data, non-last transfer inside a message has no effect.
        fork
            send_msg(5, 4, 2);
            recv_msg(5, 4, 1);
        join
        fork
            send_msg(60, 14, 30);
            recv_msg(60, 14, 2);
        join
        @(negedge clk);
        idle_chk("R13 idle after gapped message");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule